// File: doc/BRIEF.md
# PWM Channel Counter and Comparator

This block is a single channel of a small pulse-width modulation controller that carries four identical channels. Each channel is built from three pieces: a selector that picks one count-enable strobe out of the shared clock generator, a 16-bit counter that moves on that strobe, and a comparator that turns the counter value into the channel's output waveform.

Two alignments are offered. With left alignment the counter climbs from zero and wraps after the period value, so one waveform period lasts period x prescale master-clock cycles. With center alignment it climbs to the period value and falls back to zero, which doubles the waveform period. Period, duty and alignment are held in shadow copies that reload only when a period completes. While the channel is disabled, the shadows follow the inputs, the counter rests at zero and the pin sits at its inactive level. A one-cycle event marks each completed period.

Top module: `pwm_chan`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the counter is zero, `pwm_out` is 0 and `period_evt` is 0.
- R2: `clk_sel` = 0 advances the counter on every master-clock cycle. `clk_sel` = k with 1 <= k <= NUM_DIV advances it only in cycles where `div_ticks[k-1]` is 1. Any larger `clk_sel` value stops the counter.
- R3: With left alignment (`align_center` = 0) and a period value P >= 2, the counter visits 0..P-1 and then wraps. One period lasts P strobes, and a P of 0 or 1 lasts one strobe.
- R4: With left alignment the output is at its active level exactly while the counter is below the duty value. A duty of 0 never activates it, and a duty >= P keeps it active all the time.
- R5: With center alignment (`align_center` = 1) and P >= 1, the counter goes 0,1..P,P-1..1 and then returns to 0, so one period lasts 2P strobes.
- R6: With `pol_high` = 1 the active level is 1 and the inactive level is 0. With `pol_high` = 0 the two levels are swapped.
- R7: Period, duty and alignment values presented in the middle of a period have no effect until the strobe that completes that period. At that strobe they are captured for the next period.
- R8: While `enable` = 0 the counter stays at 0, `pwm_out` shows the inactive level and `period_evt` stays 0. The first enabled period uses the inputs present when the channel was enabled.
- R9: `period_evt` is 1 for exactly one cycle per completed period, in the cycle right after the completing strobe. On that same cycle the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable |
| clk_sel | input | SEL_W | Count-strobe select: 0 is the master clock, k is `div_ticks[k-1]` |
| div_ticks | input | NUM_DIV | Prescaled/divided enable strobes from the clock generator |
| align_center | input | 1 | 0 for left alignment, 1 for center alignment |
| pol_high | input | 1 | 1 for an active-high output, 0 for active-low |
| period_in | input | CNT_W | Period value P |
| duty_in | input | CNT_W | Duty compare value |
| pwm_out | output | 1 | Registered waveform output |
| period_evt | output | 1 | One-cycle completed-period event |

## Verification
Every result is registered once. The counter value, the pin level and the period event all respond to the inputs held at a rising edge, and they become visible just after that same edge. A shadowed period, duty or alignment value only shows up after the next period-completing strobe. The bench holds its inputs from the falling edge onward, compares the outputs a few nanoseconds after each rising edge against a cycle model that advances on that same edge, and counts events and active cycles over fixed windows for the directed period and duty cases.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic { ALIGN_LEFT = 1'b0, ALIGN_CENTER = 1'b1 } align_e;
  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;
endpackage

// File: rtl/pwm_clk_sel.sv
module pwm_clk_sel #(
  parameter int NUM_DIV = 4,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_DIV-1:0] div_ticks_i,
  output logic               tick_o
);
  localparam int NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0] slots;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == 0) begin : g_mck
      assign slots[g] = 1'b1;
    end else if (g <= NUM_DIV) begin : g_div
      assign slots[g] = div_ticks_i[g-1];
    end else begin : g_off
      assign slots[g] = 1'b0;
    end
  end

  assign tick_o = slots[sel_i];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [CNT_W-1:0] duty_d_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  dir_e             dir_q, dir_d;
  align_e           mode_q, mode_d;
  logic             evt_q, bnd;

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    per_d  = per_q;
    duty_d = duty_q;
    mode_d = mode_q;
    bnd    = 1'b0;
    if (!enable_i) begin
      cnt_d  = ZERO;
      dir_d  = DIR_UP;
      per_d  = period_i;
      duty_d = duty_i;
      mode_d = align_e'(center_i);
    end else if (tick_i) begin
      if (mode_q == ALIGN_LEFT) begin
        if (per_q <= ONE || cnt_q >= per_q - ONE) bnd = 1'b1;
        else cnt_d = cnt_q + ONE;
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= per_q) begin
          if (per_q <= ONE) begin
            bnd = 1'b1;
          end else begin
            cnt_d = per_q - ONE;
            dir_d = DIR_DOWN;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) bnd = 1'b1;
        else cnt_d = cnt_q - ONE;
      end
      if (bnd) begin
        cnt_d  = ZERO;
        dir_d  = DIR_UP;
        per_d  = period_i;
        duty_d = duty_i;
        mode_d = align_e'(center_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      dir_q  <= DIR_UP;
      per_q  <= ZERO;
      duty_q <= ZERO;
      mode_q <= ALIGN_LEFT;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      mode_q <= mode_d;
      evt_q  <= bnd;
    end
  end

  assign cnt_d_o  = cnt_d;
  assign duty_d_o = duty_d;
  assign evt_o    = evt_q;

  p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> cnt_q == ZERO);
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !tick_i) |=> $stable(cnt_q));
  p_left_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ALIGN_LEFT && per_q > ONE) |-> cnt_q < per_q);
  p_center_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ALIGN_CENTER && per_q != ZERO) |-> cnt_q <= per_q);
  p_evt_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> cnt_q == ZERO);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic active, pwm_d, pwm_q;

  always_comb begin
    active = enable_i && (cnt_i < duty_i);
    pwm_d  = active ? pol_i : !pol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  p_disabled_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> pwm_q == !$past(pol_i));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int NUM_DIV = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = $clog2(NUM_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [NUM_DIV-1:0] div_ticks,
  input  logic               align_center,
  input  logic               pol_high,
  input  logic [CNT_W-1:0]   period_in,
  input  logic [CNT_W-1:0]   duty_in,
  output logic               pwm_out,
  output logic               period_evt
);
  logic             tick;
  logic [CNT_W-1:0] cnt_d, duty_d;

  pwm_clk_sel #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W)) u_sel (
    .sel_i(clk_sel), .div_ticks_i(div_ticks), .tick_o(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .tick_i(tick),
    .center_i(align_center), .period_i(period_in), .duty_i(duty_in),
    .cnt_d_o(cnt_d), .duty_d_o(duty_d), .evt_o(period_evt)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .pol_i(pol_high),
    .cnt_i(cnt_d), .duty_i(duty_d), .pwm_o(pwm_out)
  );

  p_evt_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> $past(enable));
endmodule

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
  localparam int NUM_DIV = 4;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = $clog2(NUM_DIV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [SEL_W-1:0] clk_sel = '0;
  logic [NUM_DIV-1:0] div_ticks = '0;
  logic align_center = 1'b0;
  logic pol_high = 1'b1;
  logic [CNT_W-1:0] period_in = '0;
  logic [CNT_W-1:0] duty_in = '0;
  logic pwm_out, period_evt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R3";
  int tick_pct = 100;
  int evt_seen = 0;
  int act_seen = 0;

  always #4 clk = ~clk;

  pwm_chan #(.NUM_DIV(NUM_DIV), .CNT_W(CNT_W)) u_pwm_chan (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
    .div_ticks(div_ticks), .align_center(align_center), .pol_high(pol_high),
    .period_in(period_in), .duty_in(duty_in), .pwm_out(pwm_out),
    .period_evt(period_evt)
  );

  // cycle model built from the requirements
  int  m_cnt, m_per, m_duty;
  bit  m_down, m_center, m_evt, m_pwm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_down = 0; m_center = 0;
      m_evt = 0; m_pwm = 0;
    end else begin
      bit tk, bnd;
      bnd = 0;
      if (clk_sel == 0) tk = 1;
      else if (clk_sel <= NUM_DIV) tk = div_ticks[clk_sel-1];
      else tk = 0;
      if (!enable) begin
        m_cnt = 0; m_down = 0; m_per = period_in; m_duty = duty_in;
        m_center = align_center;
      end else if (tk) begin
        if (!m_center) begin
          if (m_per <= 1 || m_cnt >= m_per - 1) bnd = 1; else m_cnt++;
        end else if (!m_down) begin
          if (m_cnt >= m_per) begin
            if (m_per <= 1) bnd = 1;
            else begin m_cnt = m_per - 1; m_down = 1; end
          end else m_cnt++;
        end else begin
          if (m_cnt <= 1) bnd = 1; else m_cnt--;
        end
        if (bnd) begin
          m_cnt = 0; m_down = 0; m_per = period_in; m_duty = duty_in;
          m_center = align_center;
        end
      end
      m_evt = bnd;
      m_pwm = (enable && m_cnt < m_duty) ? pol_high : !pol_high;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: compare just after the edge, then drive at the falling edge
  task automatic cycle();
    @(posedge clk);
    #3;
    check(pwm_out === m_pwm, cur_req, "pwm_out", int'(pwm_out), int'(m_pwm));
    check(period_evt === m_evt, cur_req, "period_evt", int'(period_evt), int'(m_evt));
    if (period_evt === 1'b1) evt_seen++;
    if (pwm_out === pol_high) act_seen++;
    #1;
    for (int i = 0; i < NUM_DIV; i++)
      div_ticks[i] = ($urandom_range(99) < tick_pct);
  endtask

  task automatic setup(input int sel, input bit ctr, input bit pol,
                       input int per, input int duty);
    enable = 0; clk_sel = SEL_W'(sel); align_center = ctr; pol_high = pol;
    period_in = CNT_W'(per); duty_in = CNT_W'(duty);
    cycle(); cycle();
    enable = 1; evt_seen = 0; act_seen = 0;
  endtask

  task automatic window(input string req, input int sel, input bit ctr,
                        input bit pol, input int per, input int duty,
                        input int n, input int exp_evt, input int exp_act);
    cur_req = req;
    setup(sel, ctr, pol, per, duty);
    for (int i = 0; i < n; i++) cycle();
    if (exp_evt >= 0) check(evt_seen == exp_evt, req, "event count", evt_seen, exp_evt);
    if (exp_act >= 0) check(act_seen == exp_act, req, "active cycles", act_seen, exp_act);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    #2;
    check(pwm_out === 1'b0, "R1", "pwm_out in reset", int'(pwm_out), 0);
    check(period_evt === 1'b0, "R1", "period_evt in reset", int'(period_evt), 0);
    #20;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #3;
    check(pwm_out === 1'b0, "R1", "pwm_out after reset", int'(pwm_out), 0);
    check(period_evt === 1'b0, "R1", "period_evt after reset", int'(period_evt), 0);
    #1;

    // R3: left, P=5, every cycle -> 8 periods in 40
    window("R3", 0, 0, 1, 5, 2, 40, 8, 16);
    // R4: duty 3 of 8 -> 15 active of 40; duty 0 -> none; duty>=P -> all
    window("R4", 0, 0, 1, 8, 3, 40, 5, 15);
    window("R4", 0, 0, 1, 8, 0, 40, 5, 0);
    window("R4", 0, 0, 1, 8, 20, 40, 5, 40);
    // R6: active-low, same duty -> 15 cycles at level 0
    window("R6", 0, 0, 0, 8, 3, 40, 5, 15);
    // R5: center, P=5 -> 4 periods in 40
    window("R5", 0, 1, 1, 5, 2, 40, 4, -1);
    // R9: P=1 left -> event every cycle
    window("R9", 0, 0, 1, 1, 1, 20, 20, -1);
    // R2: unused select stops the counter; divided source with no strobes
    window("R2", NUM_DIV + 1, 0, 1, 4, 1, 30, 0, 30);
    tick_pct = 0;
    window("R2", 2, 0, 1, 4, 1, 30, 0, 30);
    tick_pct = 50;
    window("R2", 3, 1, 1, 6, 3, 120, -1, -1);
    tick_pct = 100;
    // R7: change mid-period; the first period still lasts 10
    cur_req = "R7";
    setup(0, 0, 1, 10, 5);
    cycle(); cycle(); cycle();
    period_in = 16'd3; duty_in = 16'd1; align_center = 1;
    for (int i = 0; i < 7; i++) cycle();
    check(evt_seen == 1, "R7", "event after old period", evt_seen, 1);
    for (int i = 0; i < 18; i++) cycle();
    check(evt_seen == 4, "R7", "events after new period", evt_seen, 4);
    // R8: disabled -> inactive level, no events
    cur_req = "R8";
    enable = 0; pol_high = 0; evt_seen = 0;
    for (int i = 0; i < 12; i++) cycle();
    check(evt_seen == 0, "R8", "events while disabled", evt_seen, 0);
    check(pwm_out === 1'b1, "R8", "inactive level", int'(pwm_out), 1);

    // random phases with mid-phase register changes
    for (int ph = 0; ph < 40; ph++) begin
      tick_pct = $urandom_range(100);
      cur_req = ($urandom_range(1) == 1) ? "R5" : "R3";
      setup($urandom_range(NUM_DIV + 1), cur_req == "R5", $urandom_range(1),
            $urandom_range(12), $urandom_range(14));
      for (int i = 0; i < 80; i++) begin
        if ($urandom_range(15) == 0) begin
          cur_req = "R7";
          period_in = CNT_W'($urandom_range(12));
          duty_in = CNT_W'($urandom_range(14));
          align_center = $urandom_range(1);
        end
        if ($urandom_range(31) == 0) begin
          cur_req = "R8";
          enable = !enable;
        end
        if ($urandom_range(31) == 0) begin
          cur_req = "R6";
          pol_high = !pol_high;
        end
        cycle();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule